// File: doc/BRIEF.md
# Set-Associative Data Cache with Least-Recently-Used Replacement

This block is a small data cache placed between a load/store requester and a slower word-addressed memory. Three parameters set its shape: total capacity in words, block size in words, and the number of ways. The block count is the capacity divided by the block size, and the set count is the block count divided by the number of ways. Every word address maps to exactly one set. The lowest address bits select the word within a block. The next bits select the set. All remaining upper bits form the tag. With the default values the cache holds eight one-word blocks, arranged as four sets of two ways.

A read that hits returns its word one cycle after it is accepted, and the requester can issue a new request in every cycle. A read that misses holds `ready` low. While `ready` is low, the cache fetches every word of the block from memory in ascending order, starting at the block base. It places the block in the chosen way of the indexed set and then returns the requested word. The cache picks an empty way first. If the set is full, it evicts the way in that set that was used least recently. Stores are write-through with no allocation: each store becomes one memory write, and a store that hits also updates the cached copy. Three counters record accepted accesses, hits and misses, so that miss rates can be measured over known access loops.

Top module: `lru_cache`

## Requirements
- R1: The address is split as offset = addr mod BLK_WORDS, set = (addr / BLK_WORDS) mod SETS, tag = addr / (BLK_WORDS*SETS), where SETS = CAP_WORDS/BLK_WORDS/WAYS. With the defaults (8 words, 1-word blocks, 2 ways, so 4 sets), running the read loop over words 1,3,2 five times from reset gives 3 misses in 15 accesses. Two words in one set, for example 0 and 8, both stay resident: 2 misses in 10.
- R2: After reset no way is valid, all three counters read 0, `ready` is 1, and `rsp_valid` and `mem_req` are 0. As a result, the first access to any block misses.
- R3: A read that hits produces `rsp_valid`=1 with the stored word in the cycle after the request is accepted, and `ready` stays high.
- R4: After a read miss is accepted, `ready` is low until the response. The cache requests block words from memory in ascending order, starting at the block base, and holds `mem_req` and `mem_addr` until `mem_ack` arrives. After the last word it returns the requested word with `rsp_valid`=1.
- R5: A miss fills the lowest-numbered invalid way of the set. If no way is invalid, it fills the least recently used way. A given tag is present in at most one way of a set.
- R6: Recency is updated on every hit, read or write, and on every fill. In a two-way set holding A and B with B used last, a hit on A makes B the next victim.
- R7: With BLK_WORDS=4, one miss loads all four words of the block, so that later reads of neighbouring words hit. The loop over words 1,3,2 run five times gives 1 miss in 15 accesses.
- R8: Each accepted store issues exactly one memory write with the same address and data, with `mem_we`=1. `ready` stays low until `mem_ack`, and `rsp_valid` then pulses. A store that misses allocates nothing, so a following read of that word misses. A store that hits updates the cached word, so a following read hits and returns the new value.
- R9: `cnt_access` increments on every accepted request. `cnt_hit` increments on those that hit, and `cnt_miss` increments on those that miss. `cnt_access` always equals `cnt_hit + cnt_miss`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request; accepted when `ready` is 1 at the clock edge |
| we | input | 1 | 1 = store, 0 = load |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Store data |
| ready | output | 1 | Cache is idle and can accept a request |
| rsp_valid | output | 1 | One-cycle pulse when an access completes |
| rdata | output | DATA_W | Load result, valid with `rsp_valid` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completion pulse |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| cnt_access | output | CNT_W | Accepted request count |
| cnt_hit | output | CNT_W | Hit count |
| cnt_miss | output | CNT_W | Miss count |

## Verification
A read hit is due at the first falling edge after the accepting edge. The bench samples there and expects `rsp_valid` with a stall of zero cycles. A read miss or a store completes only after memory has acknowledged every word involved. For that case the bench counts falling edges until `rsp_valid`, requires `ready` to stay low on each of them, and requires at least BLK_WORDS times the memory latency. The counters change on the accepting edge, so they are compared against a bench reference model at the response edge of every access. The reference model tracks recency with timestamps rather than age ranks.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } cache_st_e;

  // width needed to index n items, never below one bit
  function automatic int unsigned bits_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // true bit count of a power-of-two quantity (0 for n == 1)
  function automatic int unsigned log2_exact(input int unsigned n);
    return (n > 1) ? $clog2(n) : 0;
  endfunction

endpackage

// File: rtl/cache_tags.sv
module cache_tags #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int IDX_W = 2,
  parameter int TAG_W = 4,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [WAYS-1:0]  hit_vec,
  output logic [WAYS-1:0]  lk_valid,
  input  logic             ins_en,
  input  logic [IDX_W-1:0] ins_idx,
  input  logic [WAY_W-1:0] ins_way,
  input  logic [TAG_W-1:0] ins_tag
);

  logic [WAYS-1:0]  valid_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];

  assign lk_valid = valid_q[lk_idx];

  for (genvar gw = 0; gw < WAYS; gw++) begin : g_cmp
    assign hit_vec[gw] = valid_q[lk_idx][gw] && (tag_q[lk_idx][gw] == lk_tag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (ins_en) begin
      valid_q[ins_idx][ins_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) tag_q[ins_idx][ins_way] <= ins_tag;
  end

  AST_ONE_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R5

endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int IDX_W = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [WAYS-1:0]  lk_valid,
  output logic [WAY_W-1:0] victim,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [WAY_W-1:0] touch_way
);

  localparam int AGE_W = WAY_W;

  // age 0 = most recent, WAYS-1 = least recent; ages form a permutation
  logic [AGE_W-1:0] age_q [SETS][WAYS];
  logic             pick_free;

  always_comb begin
    victim    = '0;
    pick_free = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!lk_valid[w] && !pick_free) begin
        victim    = WAY_W'(w);
        pick_free = 1'b1;
      end
    end
    if (!pick_free) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[lk_idx][w] == AGE_W'(WAYS - 1)) victim = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_idx][w] <= '0;
        else if (age_q[touch_idx][w] < age_q[touch_idx][touch_way])
          age_q[touch_idx][w] <= age_q[touch_idx][w] + 1'b1;
      end
    end
  end

  AST_TOUCHED_IS_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> age_q[$past(touch_idx)][$past(touch_way)] == '0); // R6

endmodule

// File: rtl/cache_data.sv
module cache_data #(
  parameter int SETS      = 4,
  parameter int WAYS      = 2,
  parameter int BLK_WORDS = 1,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 2,
  parameter int WAY_W     = 1,
  parameter int OFF_W     = 1
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int ENTRIES = SETS * WAYS * BLK_WORDS;
  localparam int LOC_W   = cache_pkg::bits_for(ENTRIES);

  logic [DATA_W-1:0] store_q [ENTRIES];

  function automatic logic [LOC_W-1:0] loc(input logic [IDX_W-1:0] i,
                                           input logic [WAY_W-1:0] w,
                                           input logic [OFF_W-1:0] o);
    return LOC_W'((int'(i) * WAYS + int'(w)) * BLK_WORDS + int'(o));
  endfunction

  assign rd_data = store_q[loc(rd_idx, rd_way, rd_off)];

  always_ff @(posedge clk) begin
    if (wr_en) store_q[loc(wr_idx, wr_way, wr_off)] <= wr_data;
  end

endmodule

// File: rtl/cache_stats.sv
module cache_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_hit,
  output logic [CNT_W-1:0] cnt_access,
  output logic [CNT_W-1:0] cnt_hit,
  output logic [CNT_W-1:0] cnt_miss
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_access <= '0;
      cnt_hit    <= '0;
      cnt_miss   <= '0;
    end else if (acc_en) begin
      cnt_access <= cnt_access + 1'b1;
      if (acc_hit) cnt_hit  <= cnt_hit + 1'b1;
      else         cnt_miss <= cnt_miss + 1'b1;
    end
  end

  AST_CNT_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_access == CNT_W'(cnt_hit + cnt_miss)); // R9

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> $stable(cnt_access)); // R9

endmodule

// File: rtl/lru_cache.sv
module lru_cache #(
  parameter int CAP_WORDS = 8,
  parameter int BLK_WORDS = 1,
  parameter int WAYS      = 2,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  cnt_access,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_miss
);
  import cache_pkg::*;

  localparam int BLOCKS = CAP_WORDS / BLK_WORDS;
  localparam int SETS   = BLOCKS / WAYS;
  localparam int OFF_W  = bits_for(BLK_WORDS);
  localparam int IDX_W  = bits_for(SETS);
  localparam int WAY_W  = bits_for(WAYS);
  localparam int TAG_W  = ADDR_W - log2_exact(BLK_WORDS) - log2_exact(SETS);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BLK_WORDS - 1);

  // address split
  function automatic logic [OFF_W-1:0] off_of(input logic [ADDR_W-1:0] a);
    return OFF_W'(a % BLK_WORDS);
  endfunction
  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return IDX_W'((a / BLK_WORDS) % SETS);
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return TAG_W'(a / (BLK_WORDS * SETS));
  endfunction
  function automatic logic [ADDR_W-1:0] base_of(input logic [ADDR_W-1:0] a);
    return ADDR_W'((a / BLK_WORDS) * BLK_WORDS);
  endfunction

  cache_st_e         state;
  logic [ADDR_W-1:0] q_addr;
  logic [WAY_W-1:0]  fill_way;
  logic [OFF_W-1:0]  fill_cnt;

  // lookup and named events
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic [OFF_W-1:0]  lk_off;
  logic [WAYS-1:0]   hit_vec;
  logic [WAYS-1:0]   lk_valid;
  logic              lk_hit;
  logic [WAY_W-1:0]  hit_way;
  logic [WAY_W-1:0]  victim;
  logic [DATA_W-1:0] hit_data;
  logic              acc;
  logic              rd_hit_acc;
  logic              rd_miss_acc;
  logic              wr_acc;
  logic              wr_hit_acc;
  logic              fill_beat;
  logic              fill_done;

  logic              touch_en;
  logic [IDX_W-1:0]  touch_idx;
  logic [WAY_W-1:0]  touch_way;
  logic              dw_en;
  logic [IDX_W-1:0]  dw_idx;
  logic [WAY_W-1:0]  dw_way;
  logic [OFF_W-1:0]  dw_off;
  logic [DATA_W-1:0] dw_data;

  assign ready  = (state == ST_IDLE);
  assign lk_idx = idx_of(addr);
  assign lk_tag = tag_of(addr);
  assign lk_off = off_of(addr);
  assign lk_hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  assign acc         = req && ready;
  assign rd_hit_acc  = acc && !we && lk_hit;
  assign rd_miss_acc = acc && !we && !lk_hit;
  assign wr_acc      = acc && we;
  assign wr_hit_acc  = wr_acc && lk_hit;
  assign fill_beat   = (state == ST_FILL) && mem_ack;
  assign fill_done   = fill_beat && (fill_cnt == LAST_OFF);

  assign touch_en  = rd_hit_acc || wr_hit_acc || fill_done;
  assign touch_idx = fill_done ? idx_of(q_addr) : lk_idx;
  assign touch_way = fill_done ? fill_way : hit_way;

  assign dw_en   = wr_hit_acc || fill_beat;
  assign dw_idx  = fill_beat ? idx_of(q_addr) : lk_idx;
  assign dw_way  = fill_beat ? fill_way : hit_way;
  assign dw_off  = fill_beat ? fill_cnt : lk_off;
  assign dw_data = fill_beat ? mem_rdata : wdata;

  cache_tags #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .TAG_W(TAG_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .hit_vec(hit_vec), .lk_valid(lk_valid),
    .ins_en(fill_done), .ins_idx(idx_of(q_addr)), .ins_way(fill_way),
    .ins_tag(tag_of(q_addr))
  );

  cache_lru #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_lru (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_valid(lk_valid), .victim(victim),
    .touch_en(touch_en), .touch_idx(touch_idx), .touch_way(touch_way)
  );

  cache_data #(
    .SETS(SETS), .WAYS(WAYS), .BLK_WORDS(BLK_WORDS), .DATA_W(DATA_W),
    .IDX_W(IDX_W), .WAY_W(WAY_W), .OFF_W(OFF_W)
  ) u_data (
    .clk(clk),
    .rd_idx(lk_idx), .rd_way(hit_way), .rd_off(lk_off), .rd_data(hit_data),
    .wr_en(dw_en), .wr_idx(dw_idx), .wr_way(dw_way), .wr_off(dw_off),
    .wr_data(dw_data)
  );

  cache_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .acc_en(acc), .acc_hit(lk_hit),
    .cnt_access(cnt_access), .cnt_hit(cnt_hit), .cnt_miss(cnt_miss)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      q_addr    <= '0;
      fill_way  <= '0;
      fill_cnt  <= '0;
      rsp_valid <= 1'b0;
      rdata     <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (wr_acc) begin
            state     <= ST_WRITE;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= addr;
            mem_wdata <= wdata;
          end else if (rd_hit_acc) begin
            rsp_valid <= 1'b1;
            rdata     <= hit_data;
          end else if (rd_miss_acc) begin
            state    <= ST_FILL;
            q_addr   <= addr;
            fill_way <= victim;
            fill_cnt <= '0;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= base_of(addr);
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            if (fill_cnt == off_of(q_addr)) rdata <= mem_rdata;
            if (fill_cnt == LAST_OFF) begin
              state     <= ST_IDLE;
              mem_req   <= 1'b0;
              rsp_valid <= 1'b1;
            end else begin
              fill_cnt <= fill_cnt + 1'b1;
              mem_addr <= mem_addr + 1'b1;
            end
          end
        end
        ST_WRITE: begin
          if (mem_ack) begin
            state     <= ST_IDLE;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            rsp_valid <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_acc |=> rsp_valid && ready); // R3

  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_miss_acc |=> !ready && mem_req && !mem_we && !rsp_valid); // R4

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R4

  AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> mem_req && mem_we && mem_addr == $past(addr)
               && mem_wdata == $past(wdata)); // R8

endmodule

// File: tb/sim_lru_cache.sv
`timescale 1ns/1ps

module sim_mem #(
  parameter int AW  = 6,
  parameter int LAT = 6
) (
  input  logic          clk,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic          ack,
  output logic [31:0]   rdata
);
  logic [31:0] store [2**AW];

  initial begin
    ack   = 1'b0;
    rdata = '0;
    for (int i = 0; i < 2**AW; i++) store[i] = i * 32'h0100_0193 + 32'h5A5A;
    forever begin
      @(negedge clk);
      if (req) begin
        repeat (LAT - 1) @(negedge clk);
        if (we) store[addr] = wdata;
        rdata = store[addr];
        ack   = 1'b1;
        @(negedge clk);
        ack = 1'b0;
      end
    end
  end
endmodule

module sim_lru_cache;
  localparam int AW  = 6;
  localparam int LAT = 6;
  localparam int WD  = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req0 = 0, we0 = 0, req1 = 0, we1 = 0;
  logic [AW-1:0] addr0 = '0, addr1 = '0;
  logic [31:0] wdata0 = '0, wdata1 = '0;
  logic rdy0, rsp0, rdy1, rsp1;
  logic [31:0] rdata0, rdata1;
  logic mreq0, mwe0, mack0, mreq1, mwe1, mack1;
  logic [AW-1:0] maddr0, maddr1;
  logic [31:0] mwd0, mrd0, mwd1, mrd1;
  logic [15:0] acc0, hit0, mis0, acc1, hit1, mis1;

  lru_cache #(.CAP_WORDS(8), .BLK_WORDS(1), .WAYS(2), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req0), .we(we0), .addr(addr0), .wdata(wdata0),
    .ready(rdy0), .rsp_valid(rsp0), .rdata(rdata0),
    .mem_req(mreq0), .mem_we(mwe0), .mem_addr(maddr0), .mem_wdata(mwd0),
    .mem_ack(mack0), .mem_rdata(mrd0),
    .cnt_access(acc0), .cnt_hit(hit0), .cnt_miss(mis0));

  lru_cache #(.CAP_WORDS(16), .BLK_WORDS(4), .WAYS(2), .ADDR_W(AW)) u1 (
    .clk(clk), .rst_n(rst_n), .req(req1), .we(we1), .addr(addr1), .wdata(wdata1),
    .ready(rdy1), .rsp_valid(rsp1), .rdata(rdata1),
    .mem_req(mreq1), .mem_we(mwe1), .mem_addr(maddr1), .mem_wdata(mwd1),
    .mem_ack(mack1), .mem_rdata(mrd1),
    .cnt_access(acc1), .cnt_hit(hit1), .cnt_miss(mis1));

  sim_mem #(.AW(AW), .LAT(LAT)) m0 (.clk(clk), .req(mreq0), .we(mwe0), .addr(maddr0),
    .wdata(mwd0), .ack(mack0), .rdata(mrd0));
  sim_mem #(.AW(AW), .LAT(LAT)) m1 (.clk(clk), .req(mreq1), .we(mwe1), .addr(maddr1),
    .wdata(mwd1), .ack(mack1), .rdata(mrd1));

  int nchk = 0, nbad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // reference: memory shadow and a timestamp-based recency model
  logic [31:0] sh0 [64];
  bit          mv [2][4][2];
  int          mt [2][4][2];
  longint      ms [2][4][2];
  longint      now_t = 0;
  int          e_acc [2], e_hit [2], e_mis [2];

  function automatic logic [31:0] init_word(input int a);
    return a * 32'h0100_0193 + 32'h5A5A;
  endfunction

  function automatic bit model_acc(input int sel, input int a, input bit w);
    int blk, sets, idx, tg, way, vic;
    bit hit;
    blk  = (sel == 0) ? 1 : 4;
    sets = (sel == 0) ? 4 : 2;
    idx  = (a / blk) % sets;
    tg   = a / (blk * sets);
    hit  = 0;
    way  = 0;
    now_t++;
    for (int k = 0; k < 2; k++)
      if (mv[sel][idx][k] && mt[sel][idx][k] == tg) begin hit = 1; way = k; end
    if (hit) ms[sel][idx][way] = now_t;
    else if (!w) begin
      vic = -1;
      for (int k = 0; k < 2; k++) if (!mv[sel][idx][k] && vic < 0) vic = k;
      if (vic < 0) vic = (ms[sel][idx][0] <= ms[sel][idx][1]) ? 0 : 1;
      mv[sel][idx][vic] = 1;
      mt[sel][idx][vic] = tg;
      ms[sel][idx][vic] = now_t;
    end
    return hit;
  endfunction

  task automatic do_op(input int sel, input bit w, input int a, input logic [31:0] wd,
                       output logic [31:0] rd, output int stall, output bit rdy_seen);
    @(negedge clk);
    if (sel == 0) begin req0 = 1; we0 = w; addr0 = AW'(a); wdata0 = wd; end
    else          begin req1 = 1; we1 = w; addr1 = AW'(a); wdata1 = wd; end
    @(negedge clk);
    req0 = 0; req1 = 0;
    stall = 0; rdy_seen = 0;
    while (((sel == 0) ? rsp0 : rsp1) == 1'b0 && stall < 4000) begin
      if ((sel == 0) ? rdy0 : rdy1) rdy_seen = 1;
      stall++;
      @(negedge clk);
    end
    rd = (sel == 0) ? rdata0 : rdata1;
  endtask

  task automatic run_op(input int sel, input bit w, input int a, input logic [31:0] wd,
                        output bit hit);
    logic [31:0] rd, expd;
    int stall, blk;
    bit rs;
    blk = (sel == 0) ? 1 : 4;
    hit = model_acc(sel, a, w);
    e_acc[sel]++;
    if (hit) e_hit[sel]++; else e_mis[sel]++;
    do_op(sel, w, a, wd, rd, stall, rs);
    if (w) sh0[a] = wd;
    expd = (sel == 0) ? sh0[a] : init_word(a);
    if (!w) chk(rd == expd, hit ? "R3" : "R4", "read data", rd, expd);
    if (!w && hit) chk(stall == 0, "R3", "hit stall cycles", stall, 0);
    else chk(stall >= blk * LAT && !rs, w ? "R8" : "R4", "stall/ready low",
             stall, blk * LAT);
    chk(((sel == 0) ? acc0 : acc1) == 16'(e_acc[sel]), "R9", "cnt_access",
        (sel == 0) ? acc0 : acc1, e_acc[sel]);
    chk(((sel == 0) ? hit0 : hit1) == 16'(e_hit[sel]), "R9", "cnt_hit",
        (sel == 0) ? hit0 : hit1, e_hit[sel]);
    chk(((sel == 0) ? mis0 : mis1) == 16'(e_mis[sel]), "R9", "cnt_miss",
        (sel == 0) ? mis0 : mis1, e_mis[sel]);
  endtask

  task automatic expect_hit(input int sel, input bit w, input int a,
                            input logic [31:0] wd, input bit exp, input string rq);
    bit h;
    run_op(sel, w, a, wd, h);
    chk(h == exp, rq, $sformatf("hit flag for word %0d", a), h, exp);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual=hung expected=completion");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    bit h;
    int m0s, m1s;
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) sh0[i] = init_word(i);
    for (int s = 0; s < 2; s++) begin
      e_acc[s] = 0; e_hit[s] = 0; e_mis[s] = 0;
      for (int i = 0; i < 4; i++)
        for (int k = 0; k < 2; k++) begin mv[s][i][k] = 0; mt[s][i][k] = 0; ms[s][i][k] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk(rdy0 == 1 && rsp0 == 0 && mreq0 == 0, "R2", "ready/rsp/mem_req", {rdy0, rsp0, mreq0}, 3'b100);
    chk(acc0 == 0 && hit0 == 0 && mis0 == 0, "R2", "counters zero", acc0 + hit0 + mis0, 0);
    expect_hit(0, 0, 1, 0, 0, "R2");

    // R1 loop over words 1,3,2: 3 misses in 15 (word 1 already missed once above)
    m0s = mis0;
    for (int it = 0; it < 5; it++) begin
      run_op(0, 0, 1, 0, h); run_op(0, 0, 3, 0, h); run_op(0, 0, 2, 0, h);
    end
    chk(mis0 - m0s == 2, "R1", "loop 1,3,2 misses after warm word 1", mis0 - m0s, 2);

    // R7 same loop with 4-word blocks: one miss
    m1s = mis1;
    for (int it = 0; it < 5; it++) begin
      run_op(1, 0, 1, 0, h); run_op(1, 0, 3, 0, h); run_op(1, 0, 2, 0, h);
    end
    chk(mis1 - m1s == 1, "R7", "block loop misses", mis1 - m1s, 1);
    expect_hit(1, 0, 0, 0, 1, "R7");

    // R1 two words in set 0 both stay resident
    m0s = mis0;
    for (int it = 0; it < 5; it++) begin run_op(0, 0, 0, 0, h); run_op(0, 0, 8, 0, h); end
    chk(mis0 - m0s == 2, "R1", "set-0 pair misses in 10", mis0 - m0s, 2);

    // R5/R6 recency in set 2 (word 2 resident)
    expect_hit(0, 0, 10, 0, 0, "R5");
    expect_hit(0, 0, 2, 0, 1, "R6");
    expect_hit(0, 0, 18, 0, 0, "R5");
    expect_hit(0, 0, 2, 0, 1, "R6");
    expect_hit(0, 0, 10, 0, 0, "R6");

    // R8 write-through, no allocate on miss, update on hit (set 3)
    expect_hit(0, 1, 63, 32'hDEAD_0001, 0, "R8");
    expect_hit(0, 0, 63, 0, 0, "R8");
    expect_hit(0, 1, 63, 32'hBEEF_0002, 1, "R8");
    expect_hit(0, 0, 63, 0, 1, "R8");

    // constrained random mix
    for (int i = 0; i < 250; i++) begin
      bit w;
      w = ($urandom % 10) < 4;
      run_op(0, w, int'($urandom % 64), $urandom, h);
    end
    for (int i = 0; i < 80; i++) run_op(1, 0, int'($urandom % 64), 0, h);

    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule